// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the bus-clock waveform and the data-line timing for an I2C master. A byte engine above it asks for one operation at a time (START, BIT, RSTART or STOP) through a valid/ready strobe pair. The generator then drives two open-drain enables, `scl_oe` and `sda_oe`. A 1 on an enable pulls that line low and a 0 releases it, so the block never drives a line high. It raises `op_done` for one cycle when the operation is finished.

Four configuration words set the timing, all counted in input-clock cycles:

- **Period:** the full SCL period, nominally the input clock rate divided by the bus rate, where the bus rate is at most 400 kHz and 100 kHz by default.
- **Low time:** the SCL low time; the high time is the period minus the low time.
- **Data setup:** the delay from SCL going low to SDA moving, typically a sixteenth of the period.
- **Restart/stop setup:** how long SCL stays high before SDA moves for a repeated START or a STOP.

The live SCL and SDA lines come back through a synchronizer. The high phase starts counting only once SCL is seen high, so a slave that stretches the clock lengthens the period. The SDA level seen at the end of each BIT's high phase is returned on `rx_bit`.

The state machine has these states:

- **IDLE:** ready for the next operation.
- **ST_HOLD:** SDA is held low while SCL is high, before SCL is pulled low.
- **LOW_A:** SCL is low, before SDA may move.
- **LOW_B:** SCL is low, after SDA has moved.
- **WAIT_HI:** SCL is released and the block waits for the line to read high.
- **HIGH:** the timed high phase of a BIT.
- **SETUP:** SCL is high, before SDA moves for an RSTART or a STOP.

Its transitions are:

- IDLE→ST_HOLD on START.
- IDLE→LOW_A on BIT, RSTART or STOP.
- LOW_A→LOW_B when the data-setup count expires.
- LOW_B→WAIT_HI when the low count expires, which releases SCL.
- WAIT_HI→HIGH for BIT, and WAIT_HI→SETUP for RSTART or STOP, once SCL is seen high.
- HIGH→IDLE, which pulls SCL low and captures `rx_bit`.
- SETUP→ST_HOLD for RSTART, which pulls SDA low.
- SETUP→IDLE for STOP, which releases SDA.
- ST_HOLD→IDLE, which pulls SCL low.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `op_done` and `rx_bit` are 0 and `op_ready` is 1.
- R2: Operation codes are 0 = START, 1 = BIT, 2 = RSTART and 3 = STOP. An operation is accepted on a clock edge where `op_valid` and `op_ready` are both 1. `op_ready` is 0 from that edge until `op_done`. `op_done` is a one-cycle pulse that rises on the same edge as the operation's last output change.
- R3: START, issued with the bus idle, sets `sda_oe` to 1 on the accept edge E. It sets `scl_oe` to 1 at E + setup_eff.
- R4: BIT, issued with SCL held low, sets `sda_oe` to the inverse of `op_bit` at E + dsu_eff. It releases `scl_oe` at E + low_eff.
- R5: After SCL is released, the high phase lasts high_eff cycles. It starts SYNC_STAGES + 1 cycles after the SCL line reads high. Each cycle a slave holds the line low adds one cycle. At the end of the high phase `scl_oe` returns to 1. `sda_oe` does not change during the high phase.
- R6: At the end of a BIT, `rx_bit` takes the SDA line level seen through the synchronizer. This is 0 when a slave pulls SDA low even though `op_bit` = 1. `rx_bit` keeps that value until the next BIT.
- R7: RSTART releases `sda_oe` at E + dsu_eff and releases `scl_oe` at E + low_eff. Once SCL is seen high and setup_eff cycles have passed, it sets `sda_oe`. setup_eff cycles later it sets `scl_oe`.
- R8: STOP sets `sda_oe` at E + dsu_eff and releases `scl_oe` at E + low_eff. Once SCL is seen high and setup_eff cycles have passed, it releases `sda_oe`. SCL stays released.
- R9: The effective values are derived from the configuration words as follows:
  - period_eff = max(period, 3).
  - low_eff = 2 if low < 2; otherwise period_eff − 1 if low ≥ period_eff; otherwise low.
  - high_eff = period_eff − low_eff.
  - dsu_eff = 1 if the data setup is 0; otherwise low_eff − 1 if it is ≥ low_eff; otherwise the data setup.
  - setup_eff = max(restart/stop setup, 1).
- R10: `op_valid` raised while `op_ready` is 0 is ignored, and the outputs follow only the operation already running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_period | input | CNT_W | SCL period in clock cycles |
| cfg_low | input | CNT_W | SCL low time in clock cycles |
| cfg_rs_setup | input | CNT_W | SCL-high time before SDA moves for RSTART/STOP |
| cfg_data_setup | input | CNT_W | Delay from SCL low to SDA change |
| op_valid | input | 1 | Operation request |
| op_code | input | 2 | 0 START, 1 BIT, 2 RSTART, 3 STOP |
| op_bit | input | 1 | Data bit for BIT (1 releases SDA) |
| op_ready | output | 1 | Generator idle, request may be accepted |
| op_done | output | 1 | One-cycle end-of-operation pulse |
| rx_bit | output | 1 | SDA level sampled at the end of the last BIT |
| scl_in | input | 1 | Live SCL line level |
| sda_in | input | 1 | Live SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The hardest case to reach is a clock-stretching slave. Here the release of SCL and the start of the high count are separated by a period that the block does not control. The bench models the open-drain line at the falling clock edge and holds SCL low for a chosen number of cycles after each release. Each operation's expected edge times therefore carry that stretch plus the synchronizer delay. Clamping is reached by programming zero words and a low time beyond the period, which drives every phase to its one- or two-cycle minimum.

// File: rtl/scl_tgen_pkg.sv
package scl_tgen_pkg;
    typedef enum logic [1:0] {
        OP_START  = 2'd0,
        OP_BIT    = 2'd1,
        OP_RSTART = 2'd2,
        OP_STOP   = 2'd3
    } tg_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ST_HOLD,
        S_LOW_A,
        S_LOW_B,
        S_WAIT_HI,
        S_HIGH,
        S_SETUP
    } tg_state_e;
endpackage

// File: rtl/scl_tgen_sync.sv
module scl_tgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff[i] <= 1'b1;
                else        ff[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff[i] <= 1'b1;
                else        ff[i] <= ff[i-1];
            end
        end
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/scl_tgen_clamp.sv
module scl_tgen_clamp #(
    parameter int W = 16
) (
    input  logic [W-1:0] period_i,
    input  logic [W-1:0] low_i,
    input  logic [W-1:0] rsu_i,
    input  logic [W-1:0] dsu_i,
    output logic [W-1:0] low_o,
    output logic [W-1:0] high_o,
    output logic [W-1:0] dsu_o,
    output logic [W-1:0] rest_o,
    output logic [W-1:0] rsu_o
);
    localparam logic [W-1:0] MIN_PER = W'(3);
    localparam logic [W-1:0] MIN_LOW = W'(2);
    localparam logic [W-1:0] ONE     = W'(1);

    logic [W-1:0] per_c;

    always_comb begin
        per_c  = (period_i < MIN_PER) ? MIN_PER : period_i;
        low_o  = (low_i < MIN_LOW) ? MIN_LOW :
                 ((low_i >= per_c) ? per_c - ONE : low_i);
        high_o = per_c - low_o;
        dsu_o  = (dsu_i == '0) ? ONE :
                 ((dsu_i >= low_o) ? low_o - ONE : dsu_i);
        rest_o = low_o - dsu_o;
        rsu_o  = (rsu_i == '0) ? ONE : rsu_i;
    end
endmodule

// File: rtl/scl_tgen_cnt.sv
module scl_tgen_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (ld)         cnt <= ld_val;
        else if (cnt != '0)  cnt <= cnt - W'(1);
    end

    assign last = (cnt == W'(1));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tgen_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_rs_setup,
    input  logic [CNT_W-1:0] cfg_data_setup,
    input  logic             op_valid,
    input  logic [1:0]       op_code,
    input  logic             op_bit,
    output logic             op_ready,
    output logic             op_done,
    output logic             rx_bit,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe
);
    logic scl_s, sda_s;

    scl_tgen_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
    scl_tgen_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

    logic [CNT_W-1:0] low_eff, high_eff, dsu_eff, rest_eff, rsu_eff;

    scl_tgen_clamp #(.W(CNT_W)) u_clamp (
        .period_i(cfg_period), .low_i(cfg_low), .rsu_i(cfg_rs_setup),
        .dsu_i(cfg_data_setup), .low_o(low_eff), .high_o(high_eff),
        .dsu_o(dsu_eff), .rest_o(rest_eff), .rsu_o(rsu_eff));

    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic [CNT_W-1:0] cnt;
    logic             last;

    scl_tgen_cnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_val),
        .cnt(cnt), .last(last));

    tg_state_e state_q, state_d;
    tg_op_e    op_q, op_d;
    logic      bit_q, bit_d;
    logic      scl_oe_q, scl_d;
    logic      sda_oe_q, sda_d;
    logic      done_q, done_d;
    logic      rx_q, rx_d;

    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        bit_d   = bit_q;
        ld      = 1'b0;
        ld_val  = '0;
        scl_d   = scl_oe_q;
        sda_d   = sda_oe_q;
        done_d  = 1'b0;
        rx_d    = rx_q;
        unique case (state_q)
            S_IDLE: begin
                if (op_valid) begin
                    op_d  = tg_op_e'(op_code);
                    bit_d = op_bit;
                    ld    = 1'b1;
                    if (tg_op_e'(op_code) == OP_START) begin
                        state_d = S_ST_HOLD;
                        ld_val  = rsu_eff;
                        sda_d   = 1'b1;
                    end else begin
                        state_d = S_LOW_A;
                        ld_val  = dsu_eff;
                    end
                end
            end
            S_ST_HOLD: begin
                if (last) begin
                    scl_d   = 1'b1;
                    done_d  = 1'b1;
                    state_d = S_IDLE;
                end
            end
            S_LOW_A: begin
                if (last) begin
                    state_d = S_LOW_B;
                    ld      = 1'b1;
                    ld_val  = rest_eff;
                    unique case (op_q)
                        OP_BIT:    sda_d = ~bit_q;
                        OP_RSTART: sda_d = 1'b0;
                        OP_STOP:   sda_d = 1'b1;
                        default:   sda_d = sda_oe_q;
                    endcase
                end
            end
            S_LOW_B: begin
                if (last) begin
                    scl_d   = 1'b0;
                    state_d = S_WAIT_HI;
                end
            end
            S_WAIT_HI: begin
                if (scl_s) begin
                    ld = 1'b1;
                    if (op_q == OP_BIT) begin
                        state_d = S_HIGH;
                        ld_val  = high_eff;
                    end else begin
                        state_d = S_SETUP;
                        ld_val  = rsu_eff;
                    end
                end
            end
            S_HIGH: begin
                if (last) begin
                    scl_d   = 1'b1;
                    done_d  = 1'b1;
                    rx_d    = sda_s;
                    state_d = S_IDLE;
                end
            end
            S_SETUP: begin
                if (last) begin
                    if (op_q == OP_RSTART) begin
                        sda_d   = 1'b1;
                        ld      = 1'b1;
                        ld_val  = rsu_eff;
                        state_d = S_ST_HOLD;
                    end else begin
                        sda_d   = 1'b0;
                        done_d  = 1'b1;
                        state_d = S_IDLE;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_START;
            bit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            bit_q   <= bit_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_oe_q <= 1'b0;
            sda_oe_q <= 1'b0;
            done_q   <= 1'b0;
            rx_q     <= 1'b0;
        end else begin
            scl_oe_q <= scl_d;
            sda_oe_q <= sda_d;
            done_q   <= done_d;
            rx_q     <= rx_d;
        end
    end

    assign op_ready = (state_q == S_IDLE);
    assign op_done  = done_q;
    assign rx_bit   = rx_q;
    assign scl_oe   = scl_oe_q;
    assign sda_oe   = sda_oe_q;

    // R2
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ready && op_valid) |=> !op_ready);

    // R5
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_HI && !scl_s) |=> (state_q == S_WAIT_HI));

    // R5
    high_sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HIGH) |=> $stable(sda_oe));

    // R9
    phase_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {S_ST_HOLD, S_LOW_A, S_LOW_B, S_HIGH, S_SETUP}) |-> (cnt != '0));

    // R7
    restart_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SETUP && op_q == OP_RSTART && last) |=> (sda_oe && !scl_oe && !op_ready));

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SETUP && op_q == OP_STOP && last) |=> (!sda_oe && !scl_oe && op_done));
endmodule

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;
    localparam int W   = 16;
    localparam int LAT = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n;
    logic [W-1:0] cfg_period, cfg_low, cfg_rs_setup, cfg_data_setup;
    logic         op_valid;
    logic [1:0]   op_code;
    logic         op_bit;
    logic         op_ready, op_done, rx_bit, scl_oe, sda_oe;
    logic         scl_in = 1'b1;
    logic         sda_in = 1'b1;

    scl_timing_gen #(.CNT_W(W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_low(cfg_low),
        .cfg_rs_setup(cfg_rs_setup), .cfg_data_setup(cfg_data_setup),
        .op_valid(op_valid), .op_code(op_code), .op_bit(op_bit),
        .op_ready(op_ready), .op_done(op_done), .rx_bit(rx_bit),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        logic [3:0] v;
        string      tag;
    } exp_t;
    exp_t q[$];

    int checks = 0;
    int errors = 0;
    logic m_rx = 0, m_done = 0, m_scl = 0, m_sda = 0;
    int   stretch_cfg = 0;
    int   str_left = 0;
    logic sda_pull = 0;

    // open-drain line model with optional stretching slave
    always @(negedge clk) begin
        if (scl_oe) begin
            str_left = stretch_cfg;
            scl_in   = 1'b0;
        end else if (str_left > 0) begin
            str_left = str_left - 1;
            scl_in   = 1'b0;
        end else begin
            scl_in = 1'b1;
        end
        sda_in = !sda_oe && !sda_pull;
    end

    // monitor: pops expected output changes and compares
    logic [3:0] prev_v = '0;
    always @(negedge clk) begin
        logic [3:0] v;
        v = {rx_bit, op_done, scl_oe, sda_oe};
        if (!rst_n) begin
            prev_v = v;
        end else begin
            while (q.size() > 0 && q[0].at < cyc) begin
                exp_t m;
                m = q.pop_front();
                checks++; errors++;
                $display("FAIL %s: change missing, actual none expected cycle %0d value %b",
                         m.tag, m.at, m.v);
            end
            if (v !== prev_v) begin
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R10: unexpected change at cycle %0d, actual %b expected %b",
                             cyc, v, prev_v);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.at != cyc || e.v !== v) begin
                        errors++;
                        $display("FAIL %s: actual cycle %0d value %b, expected cycle %0d value %b",
                                 e.tag, cyc, v, e.at, e.v);
                    end
                end
                prev_v = v;
            end
        end
    end

    function automatic int per_e();
        return (int'(cfg_period) < 3) ? 3 : int'(cfg_period);
    endfunction
    function automatic int low_e();
        if (int'(cfg_low) < 2) return 2;
        if (int'(cfg_low) >= per_e()) return per_e() - 1;
        return int'(cfg_low);
    endfunction
    function automatic int hi_e();
        return per_e() - low_e();
    endfunction
    function automatic int ds_e();
        if (cfg_data_setup == 0) return 1;
        if (int'(cfg_data_setup) >= low_e()) return low_e() - 1;
        return int'(cfg_data_setup);
    endfunction
    function automatic int su_e();
        return (cfg_rs_setup == 0) ? 1 : int'(cfg_rs_setup);
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input int at, input string tag);
        exp_t e;
        e.at  = at;
        e.v   = {m_rx, m_done, m_scl, m_sda};
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic go(input logic [1:0] code, input logic b, input logic spam, input int last);
        op_code  = code;
        op_bit   = b;
        op_valid = 1'b1;
        @(negedge clk);
        // R2: busy right after acceptance
        check(op_ready === 1'b0, "R2", "op_ready after accept", int'(op_ready), 0);
        if (spam) begin
            op_code = 2'd3; // R10: request while busy must be ignored
            @(negedge clk);
            @(negedge clk);
        end
        op_valid = 1'b0;
        while (cyc < last) @(negedge clk);
    endtask

    task automatic op_start();
        int e0;
        e0 = cyc + 1;
        m_sda = 1; push(e0, "R3");
        m_scl = 1; m_done = 1; push(e0 + su_e(), "R3");
        m_done = 0; push(e0 + su_e() + 1, "R2");
        go(2'd0, 1'b0, 1'b0, e0 + su_e() + 1);
    endtask

    task automatic op_bitx(input logic b, input logic pull, input int s,
                           input logic spam, input string tag);
        int e0, t;
        sda_pull    = pull;
        stretch_cfg = s;
        e0 = cyc + 1;
        if (m_sda != !b) begin m_sda = !b; push(e0 + ds_e(), "R4"); end
        m_scl = 0; push(e0 + low_e(), "R4");
        t = e0 + low_e() + LAT + s + hi_e();
        m_scl = 1; m_done = 1; m_rx = b & !pull; push(t, tag);
        m_done = 0; push(t + 1, "R2");
        go(2'd1, b, spam, t + 1);
        sda_pull    = 0;
        stretch_cfg = 0;
    endtask

    task automatic op_rs(input int s);
        int e0, u;
        stretch_cfg = s;
        e0 = cyc + 1;
        if (m_sda != 0) begin m_sda = 0; push(e0 + ds_e(), "R7"); end
        m_scl = 0; push(e0 + low_e(), "R7");
        u = e0 + low_e() + LAT + s + su_e();
        m_sda = 1; push(u, "R7");
        m_scl = 1; m_done = 1; push(u + su_e(), "R7");
        m_done = 0; push(u + su_e() + 1, "R2");
        go(2'd2, 1'b0, 1'b0, u + su_e() + 1);
        stretch_cfg = 0;
    endtask

    task automatic op_stop(input int s);
        int e0, u;
        stretch_cfg = s;
        e0 = cyc + 1;
        if (m_sda != 1) begin m_sda = 1; push(e0 + ds_e(), "R8"); end
        m_scl = 0; push(e0 + low_e(), "R8");
        u = e0 + low_e() + LAT + s + su_e();
        m_sda = 0; m_done = 1; push(u, "R8");
        m_done = 0; push(u + 1, "R2");
        go(2'd3, 1'b0, 1'b0, u + 1);
        stretch_cfg = 0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        op_valid = 1'b0; op_code = 2'd0; op_bit = 1'b0;
        cfg_period = 16'd20; cfg_low = 16'd10; cfg_rs_setup = 16'd6; cfg_data_setup = 16'd3;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(scl_oe === 1'b0, "R1", "scl_oe", int'(scl_oe), 0);
        check(sda_oe === 1'b0, "R1", "sda_oe", int'(sda_oe), 0);
        check(op_done === 1'b0, "R1", "op_done", int'(op_done), 0);
        check(rx_bit === 1'b0, "R1", "rx_bit", int'(rx_bit), 0);
        check(op_ready === 1'b1, "R1", "op_ready", int'(op_ready), 1);

        // nominal timing
        op_start();
        op_bitx(1'b1, 1'b0, 0, 1'b0, "R5");
        op_bitx(1'b0, 1'b0, 0, 1'b0, "R6");
        op_bitx(1'b1, 1'b1, 0, 1'b0, "R6");
        op_bitx(1'b1, 1'b0, 5, 1'b0, "R5");
        op_bitx(1'b0, 1'b0, 0, 1'b1, "R10");
        op_rs(2);
        op_bitx(1'b1, 1'b0, 0, 1'b0, "R6");
        op_stop(0);

        // R9: all-zero words clamp to minimum phases
        cfg_period = 16'd0; cfg_low = 16'd0; cfg_rs_setup = 16'd0; cfg_data_setup = 16'd0;
        op_start();
        op_bitx(1'b0, 1'b0, 0, 1'b0, "R9");
        op_bitx(1'b1, 1'b0, 2, 1'b0, "R9");
        op_stop(0);

        // R9: low beyond period and data setup beyond low
        cfg_period = 16'd10; cfg_low = 16'd15; cfg_rs_setup = 16'd3; cfg_data_setup = 16'd12;
        op_start();
        op_bitx(1'b1, 1'b0, 0, 1'b0, "R9");
        op_bitx(1'b0, 1'b0, 3, 1'b0, "R9");
        op_rs(0);
        op_stop(1);

        repeat (20) @(negedge clk);
        check(q.size() == 0, "R10", "pending expected changes", q.size(), 0);
        check(scl_oe === 1'b0 && sda_oe === 1'b0, "R8", "bus released after STOP",
              int'({scl_oe, sda_oe}), 0);
        finish_run();
    end
endmodule